// File: doc/BRIEF.md
# Processor Bus Command Generator

This block sits between a processor's three-bit bus status code and the external bus. On every clock it samples the status. When the code leaves the passive value it starts a bus cycle. It then produces the address-latch strobe, the transceiver enable and direction, and the active-low command strobes. There are strobes for memory read and write, I/O read and write, and interrupt acknowledge. Early write strobes run one clock ahead of the normal writes.

Two static inputs shape the output. Command-enable forces every command, and the data enable, to its inactive level while still driving it. A bus-mode select decides which command group the address-enable input floats. In this model, floating is shown as two output-enable signals, one for the memory group and one for the I/O group. A dual-purpose output works as an active-low peripheral data enable in I/O-bus mode. In system-bus mode it works as a cascade enable for acknowledge cycles.

Top module: `bus_cmd_gen`

## Requirements
- R1: While reset is asserted, and right after it, ALE and DEN are low and all seven command outputs are high.
- R2: ALE is high for exactly the one clock that follows the edge where a non-passive status (not 3'b111) is sampled, with 3'b111 sampled at the edge before. ALE is low at all other times.
- R3: The status codes are 000 interrupt acknowledge (INTA), 001 I/O read, 010 I/O write, 011 halt, 100 and 101 memory read, 110 memory write and 111 passive. A read or INTA strobe goes low one clock after ALE. It stays low until the edge where 111 is sampled again.
- R4: The early memory and I/O write strobes go low in the same clock as a read strobe would. The normal write strobes go low one clock later. All of them return high on the edge where 111 is sampled.
- R5: Halt (011) cycles pulse ALE but assert no command and no DEN.
- R6: DEN is high from the first command clock to the end of every non-halt cycle. DT/R is high from the ALE clock to the end of write cycles (010, 110) and low otherwise.
- R7: With command-enable low, all commands stay high, DEN stays low and the peripheral enable stays high. ALE and DT/R are unaffected.
- R8: The memory-group enable is the inverse of address-enable. The I/O-group enable is low only when address-enable is high and bus-mode is low (system-bus mode).
- R9: In I/O-bus mode, the dual-purpose output is the inverse of DEN. In system-bus mode, it is high from the ALE clock to the end of an acknowledge cycle, whatever command-enable is.
- R10: A status change during a cycle that does not pass through 111 is ignored. The commands keep following the type latched at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat | input | 3 | Processor bus status code |
| addr_en | input | 1 | Address-enable; high floats command groups |
| cmd_en | input | 1 | Command-enable; low forces commands inactive |
| io_bus | input | 1 | Bus-mode select: 1 I/O-bus, 0 system-bus |
| ale | output | 1 | Address latch strobe |
| den | output | 1 | Data transceiver enable, active high |
| dt_r | output | 1 | Transfer direction, high for write |
| n_mrdc | output | 1 | Memory read command |
| n_mwtc | output | 1 | Memory write command |
| n_amwc | output | 1 | Early memory write command |
| n_iorc | output | 1 | I/O read command |
| n_iowc | output | 1 | I/O write command |
| n_aiowc | output | 1 | Early I/O write command |
| n_inta | output | 1 | Interrupt acknowledge command |
| mce_pden | output | 1 | Cascade enable / active-low peripheral data enable |
| oe_mem | output | 1 | Drive enable for memory command group |
| oe_io | output | 1 | Drive enable for I/O command group |

## Verification
A wrong phase shows up at the ports within one clock. It can appear as a stray or doubled ALE, a command asserted during the ALE clock, or a normal write that falls with its early twin instead of one clock after. A wrong latched cycle type gives the wrong strobe from the first command clock. A cycle that fails to end keeps a command low after the clock where passive status was sampled. The sweep checks every status code in every mode combination, clock by clock, so each of these faults appears within the cycle that caused it.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  localparam int STAT_W = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_CMD1, PH_CMDN} phase_t;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA  = 3'b000, ST_IORD = 3'b001, ST_IOWR = 3'b010, ST_HALT = 3'b011,
    ST_FETCH = 3'b100, ST_MRD  = 3'b101, ST_MWR  = 3'b110, ST_PASS = 3'b111
  } stat_t;

  // active-high internal command set
  typedef struct packed {
    logic mrd;
    logic mwr;
    logic amw;
    logic iord;
    logic iowr;
    logic aiow;
    logic ack;
  } cmd_t;

  function automatic logic is_write(stat_t t);
    return (t == ST_IOWR) || (t == ST_MWR);
  endfunction

  function automatic logic moves_data(stat_t t);
    return (t != ST_HALT) && (t != ST_PASS);
  endfunction

  function automatic cmd_t cmd_of(stat_t t, phase_t p);
    cmd_t c;
    logic early, late;
    early  = (p == PH_CMD1) || (p == PH_CMDN);
    late   = (p == PH_CMDN);
    c.mrd  = early && ((t == ST_FETCH) || (t == ST_MRD));
    c.amw  = early && (t == ST_MWR);
    c.mwr  = late  && (t == ST_MWR);
    c.iord = early && (t == ST_IORD);
    c.aiow = early && (t == ST_IOWR);
    c.iowr = late  && (t == ST_IOWR);
    c.ack  = early && (t == ST_INTA);
    return c;
  endfunction
endpackage

// File: rtl/bcg_seq.sv
module bcg_seq
  import bus_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat,
  output phase_t            phase,
  output stat_t             ctype,
  output logic              cyc_start
);
  stat_t cur, prev;
  assign cur       = stat_t'(stat);
  assign cyc_start = (phase == PH_IDLE) && (prev == ST_PASS) && (cur != ST_PASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= ST_PASS;
      phase <= PH_IDLE;
      ctype <= ST_PASS;
    end else begin
      prev <= cur;
      if (cyc_start) begin
        phase <= PH_ADDR;
        ctype <= cur;
      end else if (phase != PH_IDLE && cur == ST_PASS) begin
        phase <= PH_IDLE;
        ctype <= ST_PASS;
      end else if (phase == PH_ADDR) begin
        phase <= PH_CMD1;
      end else if (phase == PH_CMD1) begin
        phase <= PH_CMDN;
      end
    end
  end
endmodule

// File: rtl/bcg_cmd.sv
module bcg_cmd
  import bus_cmd_pkg::*;
(
  input  phase_t phase,
  input  stat_t  ctype,
  input  logic   cmd_en,
  input  logic   io_bus,
  output cmd_t   cmd,
  output logic   den,
  output logic   dt_r,
  output logic   mce_pden
);
  logic   active, cmd_phase;
  cmd_t   raw;
  assign active    = (phase != PH_IDLE);
  assign cmd_phase = (phase == PH_CMD1) || (phase == PH_CMDN);
  assign raw       = cmd_of(ctype, phase);
  assign cmd       = cmd_en ? raw : '0;
  assign den       = cmd_en && cmd_phase && moves_data(ctype);
  assign dt_r      = active && is_write(ctype);
  assign mce_pden  = io_bus ? !den : (active && ctype == ST_INTA);
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bus_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] stat,
  input  logic       addr_en,
  input  logic       cmd_en,
  input  logic       io_bus,
  output logic       ale,
  output logic       den,
  output logic       dt_r,
  output logic       n_mrdc,
  output logic       n_mwtc,
  output logic       n_amwc,
  output logic       n_iorc,
  output logic       n_iowc,
  output logic       n_aiowc,
  output logic       n_inta,
  output logic       mce_pden,
  output logic       oe_mem,
  output logic       oe_io
);
  phase_t phase;
  stat_t  ctype;
  logic   cyc_start;
  cmd_t   cmd;

  bcg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stat(stat),
    .phase(phase), .ctype(ctype), .cyc_start(cyc_start)
  );

  bcg_cmd u_cmd (
    .phase(phase), .ctype(ctype), .cmd_en(cmd_en), .io_bus(io_bus),
    .cmd(cmd), .den(den), .dt_r(dt_r), .mce_pden(mce_pden)
  );

  assign ale     = (phase == PH_ADDR);
  assign n_mrdc  = !cmd.mrd;
  assign n_mwtc  = !cmd.mwr;
  assign n_amwc  = !cmd.amw;
  assign n_iorc  = !cmd.iord;
  assign n_iowc  = !cmd.iowr;
  assign n_aiowc = !cmd.aiow;
  assign n_inta  = !cmd.ack;
  assign oe_mem  = !addr_en;
  assign oe_io   = !(addr_en && !io_bus);
endmodule

// File: rtl/bus_cmd_gen_chk.sv
module bus_cmd_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] stat,
  input logic       addr_en,
  input logic       cmd_en,
  input logic       io_bus,
  input logic       ale,
  input logic       den,
  input logic       n_mrdc,
  input logic       n_mwtc,
  input logic       n_amwc,
  input logic       n_iorc,
  input logic       n_iowc,
  input logic       n_aiowc,
  input logic       n_inta,
  input logic       oe_mem,
  input logic       oe_io
);
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_ale_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ($past(stat) != 3'b111));
  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!n_mrdc, !n_mwtc, !n_iorc, !n_iowc, !n_inta}) <= 1);
  assert_no_cmd_in_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (n_mrdc && n_iorc && n_inta && n_amwc && n_aiowc));
  assert_mem_write_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(n_mwtc) |-> !$past(n_amwc));
  assert_io_write_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(n_iowc) |-> !$past(n_aiowc));
  assert_cen_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |-> (n_mrdc && n_mwtc && n_amwc && n_iorc && n_iowc && n_aiowc && n_inta && !den));
  assert_float_sys_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && !io_bus) |-> (!oe_mem && !oe_io));
  assert_float_io_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && io_bus) |-> (!oe_mem && oe_io));
endmodule

bind bus_cmd_gen bus_cmd_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat(stat), .addr_en(addr_en), .cmd_en(cmd_en),
  .io_bus(io_bus), .ale(ale), .den(den), .n_mrdc(n_mrdc), .n_mwtc(n_mwtc),
  .n_amwc(n_amwc), .n_iorc(n_iorc), .n_iowc(n_iowc), .n_aiowc(n_aiowc),
  .n_inta(n_inta), .oe_mem(oe_mem), .oe_io(oe_io)
);

// File: tb/bus_cmd_gen_test.sv
`timescale 1ns/1ps
module bus_cmd_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] stat = 3'b111;
  logic addr_en = 1'b0, cmd_en = 1'b1, io_bus = 1'b0;
  logic ale, den, dt_r, n_mrdc, n_mwtc, n_amwc, n_iorc, n_iowc, n_aiowc, n_inta;
  logic mce_pden, oe_mem, oe_io;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_cmd_gen uut (
    .clk(clk), .rst_n(rst_n), .stat(stat), .addr_en(addr_en), .cmd_en(cmd_en),
    .io_bus(io_bus), .ale(ale), .den(den), .dt_r(dt_r), .n_mrdc(n_mrdc),
    .n_mwtc(n_mwtc), .n_amwc(n_amwc), .n_iorc(n_iorc), .n_iowc(n_iowc),
    .n_aiowc(n_aiowc), .n_inta(n_inta), .mce_pden(mce_pden), .oe_mem(oe_mem),
    .oe_io(oe_io)
  );

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // k: 0 idle, 1 ALE clock, 2 first command clock, 3+ later clocks
  task automatic expect_all(int t, int k, logic cen, logic iob, logic aen);
    logic early, late, act, e_den, e_mce;
    logic [6:0] e_cmd;
    string ctag;
    act   = (k >= 1);
    early = (k >= 2);
    late  = (k >= 3);
    e_cmd = ~({early && (t == 4 || t == 5), late && t == 6, early && t == 6,
               early && t == 1, late && t == 2, early && t == 2, early && t == 0}
              & {7{cen}});
    e_den = cen && early && t != 3 && t != 7;
    e_mce = iob ? !e_den : (act && t == 0);
    ctag  = !cen ? "R7" : (t == 3) ? "R5" : (t == 2 || t == 6) ? "R4" : "R3";
    check("R2", "ale", {7'd0, ale}, {7'd0, k == 1});
    check(ctag, "commands", {1'b0, n_mrdc, n_mwtc, n_amwc, n_iorc, n_iowc, n_aiowc, n_inta},
          {1'b0, e_cmd});
    check("R6", "den/dtr", {6'd0, den, dt_r}, {6'd0, e_den, act && (t == 2 || t == 6)});
    check("R9", "mce_pden", {7'd0, mce_pden}, {7'd0, e_mce});
    check("R8", "oe", {6'd0, oe_mem, oe_io}, {6'd0, !aen, !(aen && !iob)});
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    // R1: reset state, both during and right after reset
    check("R1", "reset cmds", {1'b0, n_mrdc, n_mwtc, n_amwc, n_iorc, n_iowc, n_aiowc, n_inta}, 8'h7f);
    check("R1", "reset ale/den", {6'd0, ale, den}, 8'd0);
    rst_n = 1'b1;
    tick();
    expect_all(7, 0, 1'b1, 1'b0, 1'b0);

    for (int m = 0; m < 8; m++) begin
      for (int t = 0; t < 7; t++) begin
        io_bus  = m[0];
        cmd_en  = m[1];
        addr_en = m[2];
        stat    = 3'b111;
        tick();
        tick();
        expect_all(t, 0, cmd_en, io_bus, addr_en);
        stat = 3'(t);
        for (int k = 1; k <= 4; k++) begin
          tick();
          expect_all(t, k, cmd_en, io_bus, addr_en);
        end
        stat = 3'b111;
        tick();
        expect_all(t, 0, cmd_en, io_bus, addr_en);
      end
    end

    // R10: status hops to other codes mid-cycle without passing through passive
    io_bus = 1'b1; cmd_en = 1'b1; addr_en = 1'b0;
    stat = 3'b111;
    tick();
    stat = 3'b001;
    tick();
    tick();
    stat = 3'b110;
    tick();
    check("R10", "iorc held", {6'd0, n_iorc, n_mwtc}, {6'd0, 1'b0, 1'b1});
    stat = 3'b000;
    tick();
    check("R10", "no restart", {5'd0, ale, n_inta, n_iorc}, {5'd0, 1'b0, 1'b1, 1'b0});
    stat = 3'b111;
    tick();
    check("R10", "end", {7'd0, n_iorc}, 8'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule